// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block computes one output of an eight-tap FIR filter with fixed integer coefficients, and it uses no multipliers. A one-cycle start strobe captures eight signed 8-bit samples in parallel. The block then walks through the samples one bit position per clock, from the least significant bit upwards. On each step, the bit at the current position from every tap forms an address into a 256-word table. Each table word holds the sum of the coefficients whose address bit is set.

Each table word is weighted by its bit position before it enters the accumulator. The word for the top bit position is subtracted, which gives the correct result for two's-complement samples. After the last bit position, the block registers the sum on its output and pulses a valid flag for one cycle. The output value then stays unchanged until the next result arrives.

The block suits control logic that can supply a set of samples and wait about ten cycles for a single filtered value.

Top module: `da_fir_filter`

## Requirements
- R1: The coefficients, from tap 0 to tap 7, are -27, -13, 4, 12, 12, 4, -13, -27. When tap k holds 1 and every other tap holds 0, the result equals the coefficient of tap k.
- R2: When all eight taps hold 1, the result is -48, the sum of the coefficients.
- R3: For any signed 8-bit samples, the result equals the sum over k of coefficient(k)·sample(k), given as a 16-bit two's-complement value. Tap k occupies bits [8k+7:8k] of the sample input.
- R4: Suppose `start` is high at a rising edge while the block is idle. Then `y_valid` is high during the cycle that follows the ninth rising edge counted from that one, the accepting edge included.
- R5: `y_valid` is high for exactly one cycle per result.
- R6: `y_out` keeps its value in every cycle in which `y_valid` is low.
- R7: While a computation runs, `start` and any change on `samples_in` have no effect. No extra result is produced, and the running result is not altered.
- R8: After synchronous active-high reset, `y_valid` is 0 and `y_out` is 0.
- R9: The top bit position has negative weight. With -128 on every tap the result is 6144. With 127 on every tap the result is -6096.
- R10: A `start` given in the same cycle as a `y_valid` pulse is accepted. The new result follows with the latency stated in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures the samples and begins a computation when the block is idle |
| samples_in | input | 64 | Eight signed 8-bit samples; tap k in bits [8k+7:8k] |
| y_out | output | 16 | Signed filter result, held between results |
| y_valid | output | 1 | One-cycle pulse that marks a new result |

## Verification
The bench builds the block with its default parameters: eight taps, 8-bit samples, 8-bit coefficients, 8-bit table words and a 16-bit accumulator. With these values the single-bit impulses reach every one-hot table address. The all-ones step reaches the full-sum address. The -128 and 127 patterns drive the subtracted top bit position at its extremes, and a set of pseudo-random sample sets mixes the signs. Each result's arrival cycle is checked against the expected latency. The bench also places a start during a run and a start during a valid pulse.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // Weight one table word by its bit position; the sign plane is negated.
  function automatic int plane_weighted(input int term, input int idx, input bit neg);
    int v;
    v = term <<< idx;
    return neg ? -v : v;
  endfunction

endpackage

// File: rtl/da_fir_sample_bank.sv
module da_fir_sample_bank #(
  parameter int NTAPS    = 8,
  parameter int SAMPLE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic                      shift,
  input  logic [NTAPS*SAMPLE_W-1:0] samples_in,
  output logic [NTAPS-1:0]          plane
);

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic [SAMPLE_W-1:0] sreg;

    always_ff @(posedge clk) begin
      if (rst) begin
        sreg <= '0;
      end else if (load) begin
        sreg <= samples_in[k*SAMPLE_W +: SAMPLE_W];
      end else if (shift) begin
        sreg <= sreg >> 1;
      end
    end

    assign plane[k] = sreg[0];
  end

endmodule

// File: rtl/da_fir_lut.sv
module da_fir_lut #(
  parameter int                     NTAPS  = 8,
  parameter int                     COEF_W = 8,
  parameter int                     LUT_W  = 8,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic [NTAPS-1:0]        addr,
  output logic signed [LUT_W-1:0] word
);

  localparam int DEPTH = 1 << NTAPS;

  function automatic logic signed [LUT_W-1:0] table_word(input int a);
    int s;
    s = 0;
    for (int k = 0; k < NTAPS; k++) begin
      if (((a >> k) & 1) == 1) begin
        s = s + int'($signed(COEFS[k*COEF_W +: COEF_W]));
      end
    end
    return LUT_W'(s);
  endfunction

  logic signed [LUT_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign rom[a] = table_word(a);
  end

  assign word = rom[addr];

endmodule

// File: rtl/da_fir_accum.sv
module da_fir_accum
  import da_fir_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int LUT_W = 8,
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    step,
  input  logic                    subtract,
  input  logic [IDX_W-1:0]        idx,
  input  logic signed [LUT_W-1:0] term,
  output logic signed [ACC_W-1:0] acc_next
);

  logic signed [ACC_W-1:0] acc;

  always_comb begin
    acc_next = acc + ACC_W'(plane_weighted(int'(term), int'(idx), subtract));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
    end else if (step) begin
      acc <= acc_next;
    end
  end

endmodule

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl
  import da_fir_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load_fire,
  output logic             step,
  output logic             last_plane,
  output logic [IDX_W-1:0] bit_idx
);

  phase_t           phase;
  logic [IDX_W-1:0] cnt;

  assign step       = (phase == PH_RUN);
  assign load_fire  = start && (phase == PH_IDLE);
  assign last_plane = step && (cnt == IDX_W'(SAMPLE_W - 1));
  assign bit_idx    = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (load_fire) begin
      phase <= PH_RUN;
      cnt   <= '0;
    end else if (step) begin
      if (last_plane) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/da_fir_filter.sv
module da_fir_filter #(
  parameter int                      NTAPS    = 8,
  parameter int                      SAMPLE_W = 8,
  parameter int                      COEF_W   = 8,
  parameter int                      LUT_W    = 8,
  parameter int                      ACC_W    = 16,
  parameter logic [NTAPS*COEF_W-1:0] COEFS    =
    {8'hE5, 8'hF3, 8'h04, 8'h0C, 8'h0C, 8'h04, 8'hF3, 8'hE5}
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [NTAPS*SAMPLE_W-1:0] samples_in,
  output logic [ACC_W-1:0]          y_out,
  output logic                      y_valid
);

  localparam int IDX_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

  logic                    load_fire;
  logic                    step;
  logic                    last_plane;
  logic [IDX_W-1:0]        bit_idx;
  logic [NTAPS-1:0]        plane;
  logic signed [LUT_W-1:0] lut_word;
  logic signed [ACC_W-1:0] acc_next;

  da_fir_ctrl #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load_fire(load_fire), .step(step),
    .last_plane(last_plane), .bit_idx(bit_idx)
  );

  da_fir_sample_bank #(.NTAPS(NTAPS), .SAMPLE_W(SAMPLE_W)) u_bank (
    .clk(clk), .rst(rst), .load(load_fire), .shift(step),
    .samples_in(samples_in), .plane(plane)
  );

  da_fir_lut #(.NTAPS(NTAPS), .COEF_W(COEF_W), .LUT_W(LUT_W), .COEFS(COEFS)) u_lut (
    .addr(plane), .word(lut_word)
  );

  da_fir_accum #(.ACC_W(ACC_W), .LUT_W(LUT_W), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst(rst), .clear(load_fire), .step(step),
    .subtract(last_plane), .idx(bit_idx), .term(lut_word),
    .acc_next(acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out   <= '0;
      y_valid <= 1'b0;
    end else begin
      y_valid <= last_plane;
      if (last_plane) begin
        y_out <= acc_next;
      end
    end
  end

endmodule

// File: rtl/da_fir_checker.sv
module da_fir_checker #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             y_valid,
  input logic [ACC_W-1:0] y_out,
  input logic             load_fire,
  input logic             step,
  input logic             last_plane
);

  localparam int CW = $clog2(SAMPLE_W + 2) + 1;

  logic [CW-1:0] run_cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (load_fire) run_cnt <= '0;
      else if (step) run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid); // R5
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> (run_cnt == CW'(SAMPLE_W))); // R4
  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (armed && !y_valid) |-> $stable(y_out)); // R6
  AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (rst)
    (step && !last_plane) |=> step); // R7
  AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    (start && !step) |=> step); // R4

endmodule

bind da_fir_filter da_fir_checker #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .y_valid(y_valid), .y_out(y_out),
  .load_fire(load_fire), .step(step), .last_plane(last_plane)
);

// File: tb/da_fir_filter_bench.sv
`timescale 1ns/1ps
module da_fir_filter_bench;

  typedef struct {
    int    val;
    int    cyc;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] samples = '0;
  logic [15:0] y_out;
  logic        y_valid;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  item_t q[$];
  logic  [15:0] last_out = '0;
  bit    have_last = 0;
  bit    prev_valid = 0;
  int    coef[8] = '{-27, -13, 4, 12, 12, 4, -13, -27};

  da_fir_filter u_da_fir_filter (
    .clk(clk), .rst(rst), .start(start), .samples_in(samples),
    .y_out(y_out), .y_valid(y_valid)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_dot(input logic [63:0] s);
    int sum = 0;
    for (int k = 0; k < 8; k++) sum += coef[k] * int'($signed(s[k*8 +: 8]));
    return sum;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [63:0] s, input string tag, input bit push);
    @(negedge clk);
    samples = s;
    start   = 1'b1;
    if (push) q.push_back('{ref_dot(s), cyc + 9, tag});
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (y_valid) begin
        check(!prev_valid, "R5 single-cycle valid", 1, 0);
        if (q.size() == 0) begin
          check(0, "R7 unexpected result", int'($signed(y_out)), 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(int'($signed(y_out)) == it.val, it.tag, int'($signed(y_out)), it.val);
          check(cyc == it.cyc, "R4 latency", cyc, it.cyc);
        end
        last_out  = y_out;
        have_last = 1;
      end else if (have_last) begin
        check(y_out == last_out, "R6 hold", int'($signed(y_out)), int'($signed(last_out)));
      end
      prev_valid = y_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [63:0] s;
    lfsr = 32'h1D0C_5A37;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(y_valid == 1'b0, "R8 reset valid", int'(y_valid), 0);
    check(y_out == 16'd0, "R8 reset output", int'(y_out), 0);

    // R1 impulse on each tap
    for (int k = 0; k < 8; k++) begin
      s = '0;
      s[k*8 +: 8] = 8'd1;
      fire(s, $sformatf("R1 impulse tap %0d", k), 1);
      drain();
    end

    // R2 step
    fire({8{8'd1}}, "R2 step", 1);
    drain();

    // R9 sign plane extremes
    fire({8{8'h80}}, "R9 all -128", 1);
    drain();
    check(int'($signed(last_out)) == 6144, "R9 value -128", int'($signed(last_out)), 6144);
    fire({8{8'h7F}}, "R9 all 127", 1);
    drain();
    check(int'($signed(last_out)) == -6096, "R9 value 127", int'($signed(last_out)), -6096);

    // R3 mixed-sign pseudo-random sets
    for (int n = 0; n < 10; n++) begin
      for (int w = 0; w < 2; w++) begin
        for (int b = 0; b < 32; b++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        s[w*32 +: 32] = lfsr;
      end
      fire(s, "R3 mixed samples", 1);
      drain();
    end

    // R7 start and sample changes during a run are ignored
    fire({8'd3, 8'd250, 8'd17, 8'd128, 8'd5, 8'd9, 8'd200, 8'd77}, "R7 running result", 1);
    repeat (2) @(negedge clk);
    samples = {8{8'h55}};
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    samples = {8{8'hAA}};
    drain();
    repeat (15) @(negedge clk);
    check(q.size() == 0, "R7 no extra result", q.size(), 0);

    // R10 back-to-back: start during valid pulse
    fire({8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80}, "R10 first", 1);
    do @(negedge clk); while (!y_valid);
    s = {8'hF0, 8'h0F, 8'h01, 8'hFF, 8'h7F, 8'h80, 8'h22, 8'h33};
    samples = s;
    start   = 1'b1;
    q.push_back('{ref_dot(s), cyc + 9, "R10 second"});
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (12) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule